// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the hazard arbiter of a five-stage in-order processor whose stages are fetch, decode, execute, memory and writeback. It is purely combinational. Each cycle it reads the instruction class and register numbers held in the decode, execute and memory pipeline registers, the branch outcome computed in execute, and a drain request. From these it decides, for every pipeline register, whether that register holds its contents (stall) or loads an empty slot (bubble). The datapath registers, the next-PC selection and the forwarding multiplexers sit outside and consume these decisions.

The policy is fixed. An operand produced by an instruction in execute or memory is assumed to reach decode through forwarding, so it costs nothing. The one exception is a value that a memory read is still fetching: that costs one stall of the consumer. A return holds fetch until the popped address is known, which takes three cycles. Conditional jumps are predicted taken. When execute finds the condition false, the two younger instructions behind the jump are discarded. A drain request empties the pipeline by bubbling decode every cycle.

The drive side is plain control: every input is sampled as a level in the same cycle and every output is a level, so there is no valid/ready handshake and no back-pressure. The stall and bubble vectors are indexed by stage: bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory, bit 4 writeback.

Top module: `hazard_ctrl`

## Requirements
- R1: When no load/use hazard, no return and no misprediction is present and drain is low, every stall and bubble bit is 0. This includes an ALU-class producer in execute or any producer in memory that matches a decode source.
- R2: A load/use hazard exists when the execute class is a memory read (LOAD=5 or POP=11), its destination is not the no-register code, and it equals either decode source. It drives stall bit 0 and stall bit 1 high and bubble bit 2 high, and bubble bit 1 low. In a flowing pipeline it lasts exactly one cycle.
- R3: A return (class RET=9) in decode, execute or memory drives stall bit 0 high and bubble bit 1 high. When a load/use hazard is present in the same cycle, decode is stalled instead of bubbled. A return fetched into a flowing pipeline holds fetch for exactly three cycles.
- R4: A misprediction exists when the execute class is JUMP=7 with its condition input low. It drives bubble bit 1 and bubble bit 2 high and does not stall fetch by itself. Exactly two younger instructions are discarded.
- R5: Drain high drives bubble bit 1 high unless a load/use hazard is present, in which case decode is stalled. Three consecutive drain cycles leave decode, execute and memory empty.
- R6: No stage has its stall and bubble bits high together. The memory and writeback bits (3 and 4) are never set.
- R7: The all-ones register number means "no register" and never produces a load/use match, even when a source also carries it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_class | input | 4 | Instruction class in decode (NOP=0, HALT=1, MOVE=2, IMM=3, STORE=4, LOAD=5, ALU=6, JUMP=7, CALL=8, RET=9, PUSH=10, POP=11) |
| d_srcs | input | NSRC*REG_W | Decode source register numbers, source k at bits [k*REG_W +: REG_W] |
| e_class | input | 4 | Instruction class in execute |
| e_dst | input | REG_W | Destination of the memory-read result in execute |
| e_cond | input | 1 | Branch condition evaluated in execute (1 = taken) |
| m_class | input | 4 | Instruction class in memory |
| drain | input | 1 | Bubble decode every cycle to empty the pipeline |
| stall_o | output | 5 | Per-stage hold, bit 0 fetch to bit 4 writeback |
| bubble_o | output | 5 | Per-stage empty-slot load, same indexing |

## Verification
The hardest cases to reach from the ports are the overlaps: a return in decode together with a load in execute that feeds it, or a drain request during a load/use stall. In these cases stall must take priority over bubble on the decode register. A sweep over every decode and execute class, a representative set of memory classes, both condition and drain values, and every register triple of a 2-bit register file produces all of these overlaps directly. A small cycle model in the bench, driven by the unit's own outputs, then replays return, load/use, mispredict and drain sequences and counts stall cycles and discarded instructions.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  localparam int NSTG  = 5;
  localparam int ST_F  = 0;
  localparam int ST_D  = 1;
  localparam int ST_E  = 2;
  localparam int ST_M  = 3;
  localparam int ST_W  = 4;
  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    IC_NOP   = 4'd0,
    IC_HALT  = 4'd1,
    IC_MOVE  = 4'd2,
    IC_IMM   = 4'd3,
    IC_STORE = 4'd4,
    IC_LOAD  = 4'd5,
    IC_ALU   = 4'd6,
    IC_JUMP  = 4'd7,
    IC_CALL  = 4'd8,
    IC_RET   = 4'd9,
    IC_PUSH  = 4'd10,
    IC_POP   = 4'd11
  } iclass_e;

  // Per-stage response to each hazard cause.
  typedef struct packed {
    logic stall_lu;
    logic stall_ret;
    logic bub_lu;
    logic bub_mis;
    logic bub_ret;
    logic bub_drain;
  } policy_t;

  function automatic policy_t stage_policy(input int idx);
    policy_t p;
    p = '0;
    case (idx)
      ST_F: begin
        p.stall_lu  = 1'b1;
        p.stall_ret = 1'b1;
      end
      ST_D: begin
        p.stall_lu  = 1'b1;
        p.bub_mis   = 1'b1;
        p.bub_ret   = 1'b1;
        p.bub_drain = 1'b1;
      end
      ST_E: begin
        p.bub_lu  = 1'b1;
        p.bub_mis = 1'b1;
      end
      default: p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/hzc_loaduse.sv
module hzc_loaduse
  import hzc_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int NSRC  = 2
) (
  input  logic [CLS_W-1:0]      e_class,
  input  logic [REG_W-1:0]      e_dst,
  input  logic [NSRC*REG_W-1:0] d_srcs,
  output logic                  hit
);
  localparam logic [REG_W-1:0] NO_REG = {REG_W{1'b1}};

  logic [NSRC-1:0] match;
  logic            is_read;
  logic            dst_real;

  genvar s;
  generate
    for (s = 0; s < NSRC; s++) begin : g_src
      assign match[s] = (d_srcs[s*REG_W +: REG_W] == e_dst);
    end
  endgenerate

  always_comb begin
    is_read  = (e_class == IC_LOAD) || (e_class == IC_POP);
    dst_real = (e_dst != NO_REG);
    hit      = is_read && dst_real && (|match);
  end
endmodule

// File: rtl/hzc_ctrlflow.sv
module hzc_ctrlflow
  import hzc_pkg::*;
(
  input  logic [CLS_W-1:0] d_class,
  input  logic [CLS_W-1:0] e_class,
  input  logic [CLS_W-1:0] m_class,
  input  logic             e_cond,
  output logic             ret_pend,
  output logic             mispred
);
  localparam int NWATCH = 3;

  logic [NWATCH-1:0][CLS_W-1:0] watched;
  logic [NWATCH-1:0]            ret_at;

  assign watched = {m_class, e_class, d_class};

  genvar w;
  generate
    for (w = 0; w < NWATCH; w++) begin : g_watch
      assign ret_at[w] = (watched[w] == IC_RET);
    end
  endgenerate

  always_comb begin
    ret_pend = |ret_at;
    mispred  = (e_class == IC_JUMP) && !e_cond;
  end
endmodule

// File: rtl/hzc_stage_ctl.sv
module hzc_stage_ctl
  import hzc_pkg::*;
#(
  parameter policy_t POL = '0
) (
  input  logic lu,
  input  logic ret,
  input  logic mis,
  input  logic drain,
  output logic stall,
  output logic bubble
);
  logic bub_want;

  always_comb begin
    stall    = (lu & POL.stall_lu) | (ret & POL.stall_ret);
    bub_want = (lu & POL.bub_lu) | (mis & POL.bub_mis)
             | (ret & POL.bub_ret) | (drain & POL.bub_drain);
    // a held register keeps its contents; bubble yields to stall
    bubble   = bub_want & ~stall;
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hzc_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int NSRC  = 2
) (
  input  logic [CLS_W-1:0]      d_class,
  input  logic [NSRC*REG_W-1:0] d_srcs,
  input  logic [CLS_W-1:0]      e_class,
  input  logic [REG_W-1:0]      e_dst,
  input  logic                  e_cond,
  input  logic [CLS_W-1:0]      m_class,
  input  logic                  drain,
  output logic [NSTG-1:0]       stall_o,
  output logic [NSTG-1:0]       bubble_o
);
  logic lu_hit;
  logic ret_pend;
  logic mispred;

  hzc_loaduse #(.REG_W(REG_W), .NSRC(NSRC)) u_lu (
    .e_class (e_class),
    .e_dst   (e_dst),
    .d_srcs  (d_srcs),
    .hit     (lu_hit)
  );

  hzc_ctrlflow u_cf (
    .d_class  (d_class),
    .e_class  (e_class),
    .m_class  (m_class),
    .e_cond   (e_cond),
    .ret_pend (ret_pend),
    .mispred  (mispred)
  );

  genvar g;
  generate
    for (g = 0; g < NSTG; g++) begin : g_stage
      hzc_stage_ctl #(.POL(stage_policy(g))) u_ctl (
        .lu     (lu_hit),
        .ret    (ret_pend),
        .mis    (mispred),
        .drain  (drain),
        .stall  (stall_o[g]),
        .bubble (bubble_o[g])
      );
    end
  endgenerate

  always_comb begin
    if (!$isunknown({d_class, d_srcs, e_class, e_dst, e_cond, m_class, drain})) begin
      // R2
      if (lu_hit)
        lu_stall_chk: assert (stall_o[ST_F] && stall_o[ST_D] && bubble_o[ST_E] && !bubble_o[ST_D]);
      // R3
      if (ret_pend)
        ret_hold_chk: assert (stall_o[ST_F] && (stall_o[ST_D] != bubble_o[ST_D]));
      // R4
      if (mispred)
        mispredict_chk: assert (bubble_o[ST_D] && bubble_o[ST_E] && !stall_o[ST_D]);
      // R6
      tail_quiet_chk: assert (stall_o[ST_W:ST_M] == '0 && bubble_o[ST_W:ST_M] == '0);
      // R1
      if (!lu_hit && !ret_pend && !mispred && !drain)
        idle_chk: assert (stall_o == '0 && bubble_o == '0);
    end
  end
endmodule

// File: tb/hazard_ctrl_test.sv
`timescale 1ns/100ps
module hazard_ctrl_test;
  localparam int RW = 2;
  localparam int NS = 2;
  localparam logic [RW-1:0] NONE = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]      d_class, e_class, m_class;
  logic [NS*RW-1:0] d_srcs;
  logic [RW-1:0]   e_dst;
  logic            e_cond, drain;
  logic [4:0]      stall_o, bubble_o;

  hazard_ctrl #(.REG_W(RW), .NSRC(NS)) uut (
    .d_class(d_class), .d_srcs(d_srcs), .e_class(e_class), .e_dst(e_dst),
    .e_cond(e_cond), .m_class(m_class), .drain(drain),
    .stall_o(stall_o), .bubble_o(bubble_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (d=%0d e=%0d m=%0d)",
               req, act, exp, d_class, e_class, m_class);
    end
  endtask

  typedef struct packed {
    logic [3:0]    c;
    logic [RW-1:0] a;
    logic [RW-1:0] b;
    logic [RW-1:0] dst;
    logic          cond;
  } ins_t;

  localparam ins_t BUB = '{c: 4'd0, a: NONE, b: NONE, dst: NONE, cond: 1'b1};

  ins_t sD, sE, sM;
  ins_t prog [0:7];
  int   pc;

  function automatic ins_t mk(input int c, input int a, input int b, input int dst, input bit cond);
    ins_t r;
    r.c = 4'(c); r.a = RW'(a); r.b = RW'(b); r.dst = RW'(dst); r.cond = cond;
    return r;
  endfunction

  task automatic reset_model();
    sD = BUB; sE = BUB; sM = BUB; pc = 0;
    for (int i = 0; i < 8; i++) prog[i] = mk(6, 0, 0, 3, 1'b1);
  endtask

  // advance the cycle model n times using the unit's decisions
  task automatic run(input int n, input bit dr, output int fstall, output int dstall, output int lost);
    fstall = 0; dstall = 0; lost = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      d_class = sD.c; d_srcs = {sD.b, sD.a};
      e_class = sE.c; e_dst = sE.dst; e_cond = sE.cond;
      m_class = sM.c; drain = dr;
      #1;
      if (stall_o[0]) fstall++;
      if (stall_o[1]) dstall++;
      if (bubble_o[2] && !stall_o[1] && sD.c != 4'd0) lost++;
      if (bubble_o[1] && !stall_o[0] && prog[pc % 8].c != 4'd0) lost++;
      sM = sE;
      sE = bubble_o[2] ? BUB : sD;
      if (!stall_o[1]) sD = bubble_o[1] ? BUB : prog[pc % 8];
      if (!stall_o[0]) pc++;
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int fs, ds, lo;
    d_class = 0; e_class = 0; m_class = 0; d_srcs = '1; e_dst = NONE;
    e_cond = 1'b1; drain = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset/idle state
    chk("R1 idle stall", int'(stall_o), 0);
    chk("R1 idle bubble", int'(bubble_o), 0);

    // near-exhaustive sweep, expected from the requirement equations
    for (int d = 0; d < 12; d++)
      for (int e = 0; e < 12; e++)
        for (int mi = 0; mi < 3; mi++)
          for (int cd = 0; cd < 2; cd++)
            for (int fl = 0; fl < 2; fl++)
              for (int v = 0; v < 64; v++) begin
                bit lu, rt, ms;
                int ra, rb, rd;
                ra = v % 4; rb = (v / 4) % 4; rd = v / 16;
                #0.5;
                d_class = 4'(d); e_class = 4'(e);
                m_class = (mi == 0) ? 4'd0 : (mi == 1) ? 4'd9 : 4'd5;
                e_cond = cd[0]; drain = fl[0];
                d_srcs = {RW'(rb), RW'(ra)}; e_dst = RW'(rd);
                #0.5;
                // R2 / R7 load-use with the no-register code excluded
                lu = (e == 5 || e == 11) && rd != 3 && (rd == ra || rd == rb);
                rt = (d == 9) || (e == 9) || (mi == 1);
                ms = (e == 7) && (cd == 0);
                chk("R2/R3 fetch stall", int'(stall_o[0]), int'(lu || rt));
                chk("R2 decode stall", int'(stall_o[1]), int'(lu));
                chk("R3/R4/R5 decode bubble", int'(bubble_o[1]), int'(!lu && (ms || rt || fl == 1)));
                chk("R2/R4 execute bubble", int'(bubble_o[2]), int'(lu || ms));
                chk("R6 memory/writeback quiet", int'({stall_o[4:3], bubble_o[4:3]}), 0);
                chk("R6 stall/bubble exclusive", int'(stall_o & bubble_o), 0);
              end

    // R3 return: three fetch-stall cycles
    reset_model();
    prog[0] = mk(9, 3, 3, 3, 1'b1);
    run(10, 1'b0, fs, ds, lo);
    chk("R3 return fetch stall cycles", fs, 3);
    chk("R3 return lost", lo, 0);

    // R2 load/use: one decode-stall cycle
    reset_model();
    prog[0] = mk(5, 3, 3, 1, 1'b1);
    prog[1] = mk(6, 1, 3, 3, 1'b1);
    run(8, 1'b0, fs, ds, lo);
    chk("R2 load/use decode stall cycles", ds, 1);
    chk("R2 load/use lost", lo, 0);

    // R1 ALU producer feeding next instruction: no stall
    reset_model();
    prog[0] = mk(6, 3, 3, 1, 1'b1);
    prog[1] = mk(6, 1, 1, 3, 1'b1);
    run(8, 1'b0, fs, ds, lo);
    chk("R1 forwarded dependency stalls", fs + ds, 0);

    // R4 mispredict: two instructions discarded, fetch never stalled
    reset_model();
    prog[0] = mk(7, 3, 3, 3, 1'b0);
    run(8, 1'b0, fs, ds, lo);
    chk("R4 mispredict discarded", lo, 2);
    chk("R4 mispredict fetch stalls", fs, 0);

    // R4 correctly predicted jump: nothing discarded
    reset_model();
    prog[0] = mk(7, 3, 3, 3, 1'b1);
    run(8, 1'b0, fs, ds, lo);
    chk("R4 taken jump discarded", lo, 0);

    // R5 drain: three cycles empty the pipeline
    reset_model();
    run(4, 1'b0, fs, ds, lo);
    run(3, 1'b1, fs, ds, lo);
    chk("R5 drain empties decode", int'(sD.c), 0);
    chk("R5 drain empties execute", int'(sE.c), 0);
    chk("R5 drain empties memory", int'(sM.c), 0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule